// File: doc/BRIEF.md
# Coded Clock-Enable Divider Bank

The block produces up to eleven clock-enable strobes from a single fast source clock. Each channel divides that clock by a ratio chosen with a 4-bit code. The codes map to ratios through a fixed, non-monotonic table. That table contains one reserved code and two odd ratios. Each channel drives a one-cycle enable pulse that downstream logic uses to qualify its registers. No derived clock is created.

Software sets the ratios through two 32-bit control words. A write only updates a pending (shadow) copy of the codes. The running dividers keep their current ratio until software sets the commit bit in the second word. After a commit, each channel takes its pending code at the end of its current output period, so no output period is ever cut short. The commit bit reads back as 1 until the last channel has switched, and then clears itself.

Codes that are reserved, out of the table's range, or forbidden on a given channel are refused field by field. A refused field keeps its previous pending value, and a sticky error flag is raised.

Top module: `cdiv_bank`

## Requirements
- R1: After reset, all pending and active codes are 0, every channel pulses once every 2 cycles, both control words read back as zero, and the error flag is 0.
- R2: Codes 0 to 12 select these ratios: 0→2, 1→3, 2→4, 3→6, 4→8, 5→12, 6→16, 7→18, 8→24, 10→36, 11→48, 12→7.
- R3: Word A (wr_sel=0) holds channels 0..5 in bits 23:20, 19:16, 15:12, 11:8, 7:4 and 3:0. Word B (wr_sel=1) holds channels 6..10 in bits 27:24, 23:20, 19:16, 15:12 and 7:4. A write changes only the pending codes, which read back at the same positions. The outputs keep their old ratio until a commit.
- R4: Writing word B with bit 31 set starts a commit. Bit 31 of word B reads 1 from the next cycle until every channel has taken its pending code, then reads 0 without any further write.
- R5: A field holding code 9 or a code above 12 is refused: that channel's pending code is unchanged, and the error flag goes to 1.
- R6: Channel 1 (word A bits 19:16) and channel 6 (word B bits 27:24) refuse code 10 in the same way. All other channels accept it.
- R7: Each enable output is high for exactly one cycle in every N source cycles, where N is its active ratio. This includes the odd ratios.
- R8: A channel's active code changes only at the edge that ends one of its output pulses.
- R9: The error flag stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for a control word |
| wr_sel | input | 1 | Word select for writes: 0 = A, 1 = B |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Word select for reads |
| rd_data | output | 32 | Pending codes of the selected word; in word B, bit 31 is the commit bit |
| div_en | output | 11 | Per-channel one-cycle enable pulses |
| cfg_err | output | 1 | Sticky refused-code flag |

## Verification
The bench builds the block with its default parameters: all eleven channels, with the code-10 exclusion on channels 1 and 6. This makes both control words and both forbidden-field positions reachable. A table walks every legal code across all channels at once and measures the enable spacing on channels 0, 6 and 10. This covers the odd ratios 3 and 7, the longest ratio 48, and the refusal of code 10 on a restricted channel next to an unrestricted one. Directed tests cover the shadow behaviour before a commit, the self-clearing commit bit, and refused codes 9 and 13 inside otherwise legal words.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

  localparam int CODE_W  = 4;
  localparam int RATIO_W = 6;
  localparam int MAX_CH  = 11;
  localparam int KICK_BIT = 31;

  // divide ratio for each code; reserved/invalid codes never reach here
  function automatic logic [RATIO_W-1:0] code_ratio(input logic [CODE_W-1:0] c);
    logic [RATIO_W-1:0] r;
    case (c)
      4'd0:  r = 6'd2;
      4'd1:  r = 6'd3;
      4'd2:  r = 6'd4;
      4'd3:  r = 6'd6;
      4'd4:  r = 6'd8;
      4'd5:  r = 6'd12;
      4'd6:  r = 6'd16;
      4'd7:  r = 6'd18;
      4'd8:  r = 6'd24;
      4'd10: r = 6'd36;
      4'd11: r = 6'd48;
      4'd12: r = 6'd7;
      default: r = 6'd2;
    endcase
    return r;
  endfunction

  function automatic logic code_ok(input logic [CODE_W-1:0] c, input logic no10);
    return (c <= 4'd12) && (c != 4'd9) && !(no10 && (c == 4'd10));
  endfunction

  // bit offset of a channel's field inside its control word
  function automatic int chan_off(input int i);
    if (i < 6)       return 20 - 4 * i;
    else if (i < 10) return 24 - 4 * (i - 6);
    else             return 4;
  endfunction

  // control word holding a channel: 0 = word A, 1 = word B
  function automatic logic chan_word(input int i);
    return (i >= 6);
  endfunction

endpackage

// File: rtl/cdiv_chan.sv
module cdiv_chan
  import cdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              en_o,
  output logic              switch_o,
  output logic [CODE_W-1:0] code_o
);

  logic [RATIO_W-1:0] cnt_q, cnt_d;
  logic [CODE_W-1:0]  act_q, act_d;
  logic [RATIO_W-1:0] ratio;
  logic               wrap;

  always_comb begin
    ratio    = code_ratio(act_q);
    wrap     = (cnt_q == ratio - 6'd1);
    switch_o = wrap && upd_i;
    cnt_d    = wrap ? '0 : cnt_q + 6'd1;
    act_d    = switch_o ? code_i : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign en_o   = wrap;
  assign code_o = act_q;

endmodule

// File: rtl/cdiv_regs.sv
module cdiv_regs
  import cdiv_pkg::*;
#(
  parameter int NUM_CH = 11,
  parameter int DATA_W = 32,
  parameter logic [NUM_CH-1:0] NO10_MASK = 11'b000_0100_0010
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic                          wr_sel,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic                          rd_sel,
  output logic [DATA_W-1:0]             rd_data,
  input  logic [NUM_CH-1:0]             sw_done,
  output logic [NUM_CH-1:0][CODE_W-1:0] pend_o,
  output logic [NUM_CH-1:0]             upd_o,
  output logic                          err_o
);

  logic [NUM_CH-1:0][CODE_W-1:0] pend_q, pend_d;
  logic [NUM_CH-1:0]             upd_q, upd_d;
  logic [NUM_CH-1:0]             bad;
  logic                          err_q, err_d;
  logic                          kick;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_field
    localparam int OFF = chan_off(i);
    localparam logic WSEL = chan_word(i);
    logic [CODE_W-1:0] fld;
    logic              hit;
    logic              ok;
    always_comb begin
      fld       = wr_data[OFF +: CODE_W];
      hit       = wr_en && (wr_sel == WSEL);
      ok        = code_ok(fld, NO10_MASK[i]);
      bad[i]    = hit && !ok;
      pend_d[i] = (hit && ok) ? fld : pend_q[i];
    end
  end

  always_comb begin
    kick  = wr_en && wr_sel && wr_data[KICK_BIT];
    upd_d = (upd_q & ~sw_done) | {NUM_CH{kick}};
    err_d = err_q | (|bad);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      upd_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      upd_q  <= upd_d;
      err_q  <= err_d;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (chan_word(i) == rd_sel)
        rd_data[chan_off(i) +: CODE_W] = pend_q[i];
    end
    if (rd_sel)
      rd_data[KICK_BIT] = |upd_q;
  end

  assign pend_o = pend_q;
  assign upd_o  = upd_q;
  assign err_o  = err_q;

endmodule

// File: rtl/cdiv_bank.sv
module cdiv_bank
  import cdiv_pkg::*;
#(
  parameter int NUM_CH = 11,
  parameter int DATA_W = 32,
  parameter logic [NUM_CH-1:0] NO10_MASK = 11'b000_0100_0010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic [NUM_CH-1:0] div_en,
  output logic              cfg_err
);

  logic [NUM_CH-1:0][CODE_W-1:0] pend_codes;
  logic [NUM_CH-1:0][CODE_W-1:0] act_codes;
  logic [NUM_CH-1:0]             upd;
  logic [NUM_CH-1:0]             sw_done;
  logic                          busy;

  cdiv_regs #(
    .NUM_CH   (NUM_CH),
    .DATA_W   (DATA_W),
    .NO10_MASK(NO10_MASK)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_sel (wr_sel),
    .wr_data(wr_data),
    .rd_sel (rd_sel),
    .rd_data(rd_data),
    .sw_done(sw_done),
    .pend_o (pend_codes),
    .upd_o  (upd),
    .err_o  (cfg_err)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    cdiv_chan u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .upd_i   (upd[i]),
      .code_i  (pend_codes[i]),
      .en_o    (div_en[i]),
      .switch_o(sw_done[i]),
      .code_o  (act_codes[i])
    );
  end

  assign busy = |upd;

endmodule

// File: rtl/cdiv_bank_chk.sv
module cdiv_bank_chk
  import cdiv_pkg::*;
#(
  parameter int NUM_CH = 11,
  parameter int DATA_W = 32,
  parameter logic [NUM_CH-1:0] NO10_MASK = 11'b000_0100_0010
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          wr_en,
  input logic                          wr_sel,
  input logic [DATA_W-1:0]             wr_data,
  input logic [NUM_CH-1:0]             div_en,
  input logic                          cfg_err,
  input logic                          busy,
  input logic [NUM_CH-1:0][CODE_W-1:0] act_codes
);

  // R7: no ratio is below 2, so a pulse is never followed by another
  a_r7_single_cycle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(div_en & $past(div_en))));

  // R9: the error flag never drops while out of reset
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  // R4: a commit write makes the commit bit busy on the next cycle
  a_r4_kick_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel && wr_data[KICK_BIT]) |=> busy);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    // R8: the active code moves only at the edge that closes a pulse
    a_r8_switch_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(act_codes[i]) |-> $past(div_en[i]));

    // R5: a reserved or out-of-range code never becomes active
    a_r5_active_legal: assert property (@(posedge clk) disable iff (!rst_n)
      (act_codes[i] <= 4'd12) && (act_codes[i] != 4'd9));

    if (NO10_MASK[i]) begin : g_no10
      // R6: restricted channels never run at code 10
      a_r6_no_code10: assert property (@(posedge clk) disable iff (!rst_n)
        act_codes[i] != 4'd10);
    end
  end

endmodule

bind cdiv_bank cdiv_bank_chk #(
  .NUM_CH   (NUM_CH),
  .DATA_W   (DATA_W),
  .NO10_MASK(NO10_MASK)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_sel   (wr_sel),
  .wr_data  (wr_data),
  .div_en   (div_en),
  .cfg_err  (cfg_err),
  .busy     (busy),
  .act_codes(act_codes)
);

// File: tb/tb_cdiv_bank.sv
module tb_cdiv_bank;

  localparam int NUM_CH = 11;
  localparam int ROWS   = 12;
  localparam int WDOG   = 150000;

  // stimulus table: {code, expected ratio}
  localparam logic [9:0] VEC [ROWS] = '{
    {4'd0, 6'd2},  {4'd1, 6'd3},  {4'd2, 6'd4},  {4'd3, 6'd6},
    {4'd4, 6'd8},  {4'd5, 6'd12}, {4'd6, 6'd16}, {4'd7, 6'd18},
    {4'd8, 6'd24}, {4'd10, 6'd36}, {4'd11, 6'd48}, {4'd12, 6'd7}
  };

  logic              clk;
  logic              rst_n;
  logic              wr_en;
  logic              wr_sel;
  logic [31:0]       wr_data;
  logic              rd_sel;
  logic [31:0]       rd_data;
  logic [NUM_CH-1:0] div_en;
  logic              cfg_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  cdiv_bank dut (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_sel (wr_sel),
    .wr_data(wr_data),
    .rd_sel (rd_sel),
    .rd_data(rd_data),
    .div_en (div_en),
    .cfg_err(cfg_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0; rd_sel = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic sel, output logic [31:0] d);
    rd_sel = sel;
    #1;
    d = rd_data;
  endtask

  task automatic wait_idle();
    logic [31:0] d;
    for (int k = 0; k < 400; k++) begin
      rd(1'b1, d);
      if (!d[31]) break;
      @(negedge clk);
    end
  endtask

  task automatic measure(input int ch, output int per);
    int k;
    k = 0;
    @(negedge clk);
    while (!div_en[ch] && k < 200) begin @(negedge clk); k++; end
    per = 0;
    do begin @(negedge clk); per++; end while (!div_en[ch] && per < 200);
  endtask

  initial begin : watchdog
    for (int k = 0; k < WDOG; k++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=<%0d", WDOG, WDOG);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    int per;
    logic [3:0] c;
    int ratio;

    do_reset();
    // R1 reset state
    rd(1'b0, d); check("R1 word A reset", d, 0);
    rd(1'b1, d); check("R1 word B reset", d, 0);
    check("R1 err reset", cfg_err, 0);
    measure(0, per); check("R1 ch0 ratio 2", per, 2);
    measure(10, per); check("R1 ch10 ratio 2", per, 2);

    // R3 pending write does not act before commit
    wr(1'b0, 32'h0020_0000);
    rd(1'b0, d); check("R3 pending readback", d, 32'h0020_0000);
    measure(0, per); check("R3 no effect before commit", per, 2);

    // R4 commit bit
    wr(1'b1, 32'h8000_0000);
    rd(1'b1, d); check("R4 commit bit set", d[31], 1);
    wait_idle();
    rd(1'b1, d); check("R4 commit bit self-clears", d[31], 0);
    measure(0, per); check("R4 ratio after commit", per, 4);

    // R2/R6/R7 table over all legal codes
    for (int r = 0; r < ROWS; r++) begin
      c     = VEC[r][9:6];
      ratio = int'(VEC[r][5:0]);
      wr(1'b0, {8'h00, c, c, c, c, c, c});
      wr(1'b1, {1'b1, 3'b000, c, c, c, c, 4'h0, c, 4'h0});
      wait_idle();
      measure(0, per);  check("R2 R7 ch0 period", per, ratio);
      measure(10, per); check("R2 R7 ch10 period", per, ratio);
      measure(6, per);
      check("R6 ch6 period", per, (c == 4'd10) ? 24 : ratio);
      check("R6 err after code 10", cfg_err, (c >= 4'd10) ? 1 : 0);
    end

    // R5 invalid code 13 on ch0 in an otherwise legal word
    do_reset();
    check("R9 err cleared by reset", cfg_err, 0);
    wr(1'b0, 32'h00D2_2222);
    rd(1'b0, d); check("R5 code 13 refused", d, 32'h0002_2222);
    check("R5 err set", cfg_err, 1);
    wr(1'b0, 32'h0022_9222);
    rd(1'b0, d); check("R5 code 9 refused", d, 32'h0022_2222);
    wr(1'b0, 32'h0022_2222);
    check("R9 err sticky after legal write", cfg_err, 1);

    // R6 directed: code 10 refused on ch6 and ch1, accepted on ch10 and ch0
    do_reset();
    wr(1'b1, 32'h0A00_00A0);
    rd(1'b1, d); check("R6 ch6 refuses, ch10 accepts", d, 32'h0000_00A0);
    check("R6 err set", cfg_err, 1);
    wr(1'b0, 32'h00AA_0000);
    rd(1'b0, d); check("R6 ch1 refuses, ch0 accepts", d, 32'h00A0_0000);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule